// File: doc/BRIEF.md
# Ancillary Packet Checksum Checker and Corrector

This block sits on a 10-bit parallel video word stream that carries a word-rate valid strobe. It finds ancillary data packets by their three-word start pattern. As each packet goes by, it builds the packet checksum and compares it with the checksum word the packet carries. Any mismatch seen during a field is gathered into a per-field error flag. That flag is published on the field-boundary strobe and then cleared.

When correction is enabled, the block writes its own calculated checksum over the received checksum word. Correction can be enabled from a pin or from a register bit. A received checksum word in the reserved code range gives a one-cycle alarm while correction is on. Every word, marked or not, passes through a three-stage delay line, so the whole packet span can be flagged on the output. The packet-active output stays aligned with the output data.

Top module: `anc_cksum_fix`

## Requirements
- R1: A packet starts when the idle parser sees the words 000h, 3FFh, 3FFh on three consecutive valid words. Words inside a packet are never taken as a new start pattern. `anc_active_o` is HIGH alongside each output word from the first start word through the checksum word, inclusive, and LOW for every other word.
- R2: The data path holds exactly three word stages. After the clock edge that accepts a valid input word k, `data_o` and `anc_active_o` show word k-2. A cycle with `valid_i` LOW changes neither output.
- R3: The calculated checksum is the 9-bit sum, wrapping, of bits 8:0 of every word from the data-ID word through the last user data word. Bit 9 of the checksum is the inverse of bit 8.
- R4: A checksum word that differs from the calculated value is a mismatch. The block keeps an internal mismatch record for the field. On a cycle where `field_i` is HIGH, `field_err_o` takes the value of that record, including a mismatch seen in that same cycle, and the record is then cleared. At all other times `field_err_o` holds its value.
- R5: Correction is enabled when `fix_pin_i` or `fix_reg_i` is HIGH. It is disabled only when both are LOW.
- R6: With correction enabled, the checksum word leaves the block as the calculated value. With correction disabled, every word, the checksum word included, leaves the block unchanged.
- R7: `bad_cksum_o` pulses HIGH for one cycle after the edge that accepts a checksum word in the range 3FCh to 3FFh, and only while correction is enabled. In every other case it is LOW.
- R8: The number of user data words is bits 7:0 of the data-count word. The data-count word is the third word after the start pattern, following the data-ID word and the secondary-ID word. A count of zero makes the next word the checksum.
- R9: While `rst_ni` is LOW, all outputs are zero and the parser is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 10 | Input video word |
| valid_i | input | 1 | Input word strobe |
| field_i | input | 1 | Field-boundary strobe |
| fix_pin_i | input | 1 | Correction enable from a pin |
| fix_reg_i | input | 1 | Correction enable from a register bit |
| data_o | output | 10 | Delayed, possibly corrected, word |
| anc_active_o | output | 1 | Packet span marker aligned with data_o |
| field_err_o | output | 1 | Checksum mismatch flag of the last completed field |
| bad_cksum_o | output | 1 | Reserved-code checksum pulse |

## Verification
The bench sends packets whose sums wrap past bit 8, so a design that left out the bit-9 inversion or the 9-bit wrap would produce the wrong corrected word. A packet with a zero data count checks that the checksum is taken from the word right after the count; an off-by-one length would drift the packet-active span. A start pattern with a foreign word between the two 3FFh words must leave the output unmarked. A mismatch arriving in the same cycle as the field strobe must show up in the published flag, and the following field must read clean. A design that dropped that mismatch, or failed to clear the record, would report the wrong field. Reserved checksum codes are sent both with correction on and with it off; a design that ignored the enable would raise the alarm in the wrong case.

// File: rtl/anc_fix_pkg.sv
package anc_fix_pkg;
  localparam int WORD_W = 10;
  localparam int SUM_W = 9;
  localparam int CNT_W = 8;
  localparam logic [WORD_W-1:0] ADF_LO = 10'h000;
  localparam logic [WORD_W-1:0] ADF_HI = 10'h3FF;
  localparam logic [WORD_W-1:0] RESV_MIN = 10'h3FC;

  typedef enum logic [2:0] {
    P_IDLE, P_DID, P_SDID, P_DC, P_UDW, P_CS
  } pstate_e;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              act;
  } stage_t;
endpackage

// File: rtl/anc_parse.sv
module anc_parse
  import anc_fix_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              en_i,
  output logic              hdr_hit_o,
  output logic              body_o,
  output logic              cs_now_o,
  output logic [WORD_W-1:0] calc_o,
  output logic              mismatch_o,
  output logic              illegal_o
);
  pstate_e           st_q;
  logic [WORD_W-1:0] p1_q, p2_q;
  logic [1:0]        hv_q;
  logic [SUM_W-1:0]  sum_q;
  logic [CNT_W-1:0]  cnt_q;

  assign hdr_hit_o  = valid_i && (st_q == P_IDLE) && (&hv_q) &&
                      (data_i == ADF_HI) && (p1_q == ADF_HI) && (p2_q == ADF_LO);
  assign body_o     = valid_i && (st_q != P_IDLE);
  assign cs_now_o   = valid_i && (st_q == P_CS);
  assign calc_o     = {~sum_q[SUM_W-1], sum_q};
  assign mismatch_o = cs_now_o && (data_i != calc_o);
  assign illegal_o  = cs_now_o && en_i && (data_i >= RESV_MIN);

  // history only counts idle words, so packet contents never form a header
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0;
      p2_q <= '0;
      hv_q <= '0;
    end else if (valid_i) begin
      if (st_q == P_IDLE && !hdr_hit_o) begin
        p1_q <= data_i;
        p2_q <= p1_q;
        hv_q <= {hv_q[0], 1'b1};
      end else begin
        hv_q <= '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= P_IDLE;
      sum_q <= '0;
      cnt_q <= '0;
    end else if (valid_i) begin
      unique case (st_q)
        P_IDLE: if (hdr_hit_o) st_q <= P_DID;
        P_DID: begin
          sum_q <= data_i[SUM_W-1:0];
          st_q  <= P_SDID;
        end
        P_SDID: begin
          sum_q <= sum_q + data_i[SUM_W-1:0];
          st_q  <= P_DC;
        end
        P_DC: begin
          sum_q <= sum_q + data_i[SUM_W-1:0];
          cnt_q <= data_i[CNT_W-1:0];
          st_q  <= (data_i[CNT_W-1:0] == '0) ? P_CS : P_UDW;
        end
        P_UDW: begin
          sum_q <= sum_q + data_i[SUM_W-1:0];
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == 1) st_q <= P_CS;
        end
        P_CS: st_q <= P_IDLE;
        default: st_q <= P_IDLE;
      endcase
    end
  end

  a_r1_hdr_enters_did: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_hit_o |=> (st_q == P_DID));
  a_r8_zero_count_to_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && st_q == P_DC && data_i[CNT_W-1:0] == '0) |=> (st_q == P_CS));
  a_r1_cs_ends_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_now_o |=> (st_q == P_IDLE));
endmodule

// File: rtl/anc_delay.sv
module anc_delay
  import anc_fix_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              act_i,
  input  logic              mark_i,
  output logic [WORD_W-1:0] word_o,
  output logic              act_o
);
  localparam int HDR_BACK = 2;  // start words already in the line at header hit

  stage_t st_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q[0] <= '0;
    end else if (valid_i) begin
      st_q[0] <= '{word: word_i, act: act_i};
    end
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[i] <= '0;
      end else if (valid_i) begin
        st_q[i].word <= st_q[i-1].word;
        st_q[i].act  <= st_q[i-1].act | (mark_i && (i <= HDR_BACK));
      end
    end
  end

  assign word_o = st_q[DEPTH-1].word;
  assign act_o  = st_q[DEPTH-1].act;

  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(word_o) && $stable(act_o)));
endmodule

// File: rtl/anc_field_flag.sv
module anc_field_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mismatch_i,
  input  logic field_i,
  output logic field_err_o
);
  logic acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= 1'b0;
      field_err_o <= 1'b0;
    end else if (field_i) begin
      field_err_o <= acc_q | mismatch_i;
      acc_q       <= 1'b0;
    end else if (mismatch_i) begin
      acc_q <= 1'b1;
    end
  end

  a_r4_flag_moves_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_i |=> $stable(field_err_o));
  a_r4_rise_needs_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_i && !acc_q && !mismatch_i) |=> !field_err_o);
endmodule

// File: rtl/anc_cksum_fix.sv
module anc_cksum_fix
  import anc_fix_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              field_i,
  input  logic              fix_pin_i,
  input  logic              fix_reg_i,
  output logic [WORD_W-1:0] data_o,
  output logic              anc_active_o,
  output logic              field_err_o,
  output logic              bad_cksum_o
);
  logic              fix_en;
  logic              hdr_hit, body, cs_now, mismatch, illegal;
  logic [WORD_W-1:0] calc, word_in;

  assign fix_en = fix_pin_i | fix_reg_i;

  anc_parse i_parse (
    .clk_i, .rst_ni, .data_i, .valid_i,
    .en_i      (fix_en),
    .hdr_hit_o (hdr_hit),
    .body_o    (body),
    .cs_now_o  (cs_now),
    .calc_o    (calc),
    .mismatch_o(mismatch),
    .illegal_o (illegal)
  );

  assign word_in = (cs_now && fix_en) ? calc : data_i;

  anc_delay #(.DEPTH(DEPTH)) i_delay (
    .clk_i, .rst_ni, .valid_i,
    .word_i (word_in),
    .act_i  (hdr_hit | body),
    .mark_i (hdr_hit),
    .word_o (data_o),
    .act_o  (anc_active_o)
  );

  anc_field_flag i_flag (
    .clk_i, .rst_ni,
    .mismatch_i (mismatch),
    .field_i,
    .field_err_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bad_cksum_o <= 1'b0;
    else         bad_cksum_o <= illegal;
  end

  a_r7_alarm_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cksum_o |-> $past(fix_pin_i || fix_reg_i));
  a_r7_alarm_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cksum_o |=> !bad_cksum_o);
endmodule

// File: tb/test_anc_cksum_fix.sv
module test_anc_cksum_fix;
  localparam int CLK_T = 10;
  localparam int NPK = 6;
  localparam int MAXW = 512;
  localparam logic [9:0] IDLE_W = 10'h040;

  typedef struct packed {
    logic [7:0] did;
    logic [7:0] sdid;
    logic [7:0] dc;
    logic [7:0] base;
    logic       bad;
    logic [9:0] csv;
    logic       pin;
    logic       rg;
  } pkt_t;

  // stimulus and expectations: correct, mismatch, fixed by pin, fixed by reg with
  // reserved code, reserved code with fix off and zero count, wrapping sum
  localparam pkt_t PKT [NPK] = '{
    '{8'h41, 8'h05, 8'd3, 8'h10, 1'b0, 10'h000, 1'b0, 1'b0},
    '{8'h50, 8'h01, 8'd2, 8'h80, 1'b1, 10'h123, 1'b0, 1'b0},
    '{8'h60, 8'h02, 8'd4, 8'h20, 1'b1, 10'h001, 1'b1, 1'b0},
    '{8'h61, 8'h03, 8'd1, 8'h30, 1'b1, 10'h3FD, 1'b0, 1'b1},
    '{8'h62, 8'h04, 8'd0, 8'h00, 1'b1, 10'h3FE, 1'b0, 1'b0},
    '{8'hFF, 8'hFF, 8'd5, 8'hF0, 1'b0, 10'h000, 1'b1, 1'b1}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       field_i = 1'b0;
  logic       fix_pin_i = 1'b0;
  logic       fix_reg_i = 1'b0;
  logic [9:0] data_o;
  logic       anc_active_o, field_err_o, bad_cksum_o;

  int checks = 0;
  int failures = 0;
  int n_sent = 0;
  bit done = 1'b0;
  logic [9:0] exp_w [MAXW];
  logic       exp_a [MAXW];

  always #(CLK_T/2) clk_i = ~clk_i;

  anc_cksum_fix i_anc_cksum_fix (
    .clk_i, .rst_ni, .data_i, .valid_i, .field_i, .fix_pin_i, .fix_reg_i,
    .data_o, .anc_active_o, .field_err_o, .bad_cksum_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // drive one word at a negedge, sample at the following negedge (R2: word k-2 visible)
  task automatic send(input logic [9:0] w, input logic [9:0] e, input logic a,
                      input logic fld);
    data_i  = w;
    valid_i = 1'b1;
    field_i = fld;
    exp_w[n_sent] = e;
    exp_a[n_sent] = a;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    field_i = 1'b0;
    if (n_sent >= 2) begin
      chk("R2_R6_data", data_o, exp_w[n_sent-2]);
      chk("R1_active", anc_active_o, exp_a[n_sent-2]);
    end
    n_sent++;
  endtask

  task automatic strobe(input logic expv, input string req);
    logic [9:0] d0;
    d0 = data_o;
    field_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    field_i = 1'b0;
    chk(req, field_err_o, expv);
    chk("R2_hold", data_o, d0);
  endtask

  // R3: 9-bit wrapping sum, bit 9 = ~bit 8
  function automatic logic [9:0] calc_cs(input pkt_t p);
    logic [8:0] s;
    s = 9'(p.did) + 9'(p.sdid) + 9'(p.dc);
    for (int i = 0; i < p.dc; i++) s = s + 9'(8'(p.base + 8'(i)));
    return {~s[8], s};
  endfunction

  task automatic run_pkt(input pkt_t p, input logic fld_on_cs);
    logic [9:0] c, rx, ex;
    logic en;
    c  = calc_cs(p);
    rx = p.bad ? p.csv : c;
    en = p.pin | p.rg;      // R5
    ex = en ? c : rx;       // R6
    fix_pin_i = p.pin;
    fix_reg_i = p.rg;
    send(IDLE_W, IDLE_W, 1'b0, 1'b0);
    send(IDLE_W, IDLE_W, 1'b0, 1'b0);
    send(10'h000, 10'h000, 1'b1, 1'b0);
    send(10'h3FF, 10'h3FF, 1'b1, 1'b0);
    send(10'h3FF, 10'h3FF, 1'b1, 1'b0);
    send({2'b00, p.did}, {2'b00, p.did}, 1'b1, 1'b0);
    send({2'b00, p.sdid}, {2'b00, p.sdid}, 1'b1, 1'b0);
    send({2'b00, p.dc}, {2'b00, p.dc}, 1'b1, 1'b0);     // R8
    for (int i = 0; i < p.dc; i++) begin
      logic [7:0] u;
      u = 8'(p.base + 8'(i));
      send({2'b00, u}, {2'b00, u}, 1'b1, 1'b0);
    end
    send(rx, ex, 1'b1, fld_on_cs);
    chk("R7_alarm", bad_cksum_o, en && (rx >= 10'h3FC));
    send(IDLE_W, IDLE_W, 1'b0, 1'b0);
    chk("R7_pulse_width", bad_cksum_o, 1'b0);
    send(IDLE_W, IDLE_W, 1'b0, 1'b0);
    if (!fld_on_cs) strobe(rx != c, "R4_field_err");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk("R9_data", data_o, 10'h000);
    chk("R9_active", anc_active_o, 1'b0);
    chk("R9_field", field_err_o, 1'b0);
    chk("R9_alarm", bad_cksum_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int k = 0; k < NPK; k++) run_pkt(PKT[k], 1'b0);

    // R1: broken start pattern is not a packet
    send(10'h000, 10'h000, 1'b0, 1'b0);
    send(10'h3FF, 10'h3FF, 1'b0, 1'b0);
    send(IDLE_W, IDLE_W, 1'b0, 1'b0);
    send(10'h3FF, 10'h3FF, 1'b0, 1'b0);
    send(10'h3FF, 10'h3FF, 1'b0, 1'b0);
    send(IDLE_W, IDLE_W, 1'b0, 1'b0);
    send(IDLE_W, IDLE_W, 1'b0, 1'b0);

    // R4: mismatch in the strobe cycle is published, then record is clear
    run_pkt(PKT[1], 1'b1);
    chk("R4_same_cycle", field_err_o, 1'b1);
    strobe(1'b0, "R4_cleared");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule